// File: doc/BRIEF.md
# Hardware Standby Power-Mode Sequencer

This block lives in the always-on power domain and decides when the chip may drop into hardware standby and how it comes back. An active-low standby request pin starts entry. Entry then stops every clock except the real-time clock, turns the oscillator off, releases the output pads and their pull-ups, and blocks interrupt and manual-reset requests. The status pin keeps its own control, selected by a register bit. If the watchdog is timing a wake-up from software standby when the request arrives, the block first lets the CPU clocks run until the CPU reports it has restarted. Only then does it fall into hardware standby.

The only way out is an ordered power-on reset. The reset pin must be low and the serial-clock strap pin high before the request pin rises. That rising edge restarts the oscillator. A settling counter then raises a clock-stable signal, and the CPU and peripheral clocks come back only once that signal is high and the synchronized reset pin has gone high. A rising request pin that breaks this order leaves the block in standby and latches an error flag. The same settling window follows release of the always-on reset. Standby requests are not acted on during that window. All three pins are synchronized by two flops on the always-on clock.

Top module: `hw_standby_ctrl`

## Requirements
- R1: While and after the always-on reset, the block is in the start-up window: osc_en=1, cpu_clk_en=0, per_clk_en=0, clk_stable=0, pad_oe=1, pad_pu=1, proto_err=0. rtc_en is 0 during reset and 1 from the first cycle after it.
- R2: clk_stable goes high exactly SETTLE_CYCLES clock cycles after the start-up window begins and stays high until hardware standby is entered.
- R3: A low standby request during the start-up window leaves the block in that window; it does not enter hardware standby.
- R4: From normal operation with wdt_exit_active=0, a low request pin puts the block in hardware standby on the third rising clock edge. There cpu_clk_en, per_clk_en and osc_en are 0 and rtc_en is 1.
- R5: In normal operation with sw_standby=1, cpu_clk_en and per_clk_en are 0, and osc_en equals wdt_exit_active. Direct entry from that state keeps the CPU clock low on every cycle.
- R6: With wdt_exit_active=1, a low request first gives a wake phase with cpu_clk_en=1, per_clk_en=1 and pads enabled. It lasts until cpu_restart_done is seen high, and hardware standby follows on the next cycle.
- R7: In hardware standby pad_oe=0 and pad_pu=0, and status_oe equals the inverse of status_hiz_sel (1 selects high impedance). Outside hardware standby pad_oe, pad_pu and status_oe are 1.
- R8: In hardware standby irq_out and mrst_out are 0 whatever irq_req and mrst_req are. Elsewhere they follow those inputs.
- R9: A rising request pin seen in hardware standby, with synchronized por_n=0 and strap_sck=1, starts the start-up window (osc_en=1, pads enabled) on the third rising edge after the pin rises.
- R10: A rising request pin in hardware standby without por_n=0 and strap_sck=1 keeps the block in hardware standby and sets proto_err. proto_err stays set until the always-on reset.
- R11: cpu_clk_en and per_clk_en return only when clk_stable is high and synchronized por_n is high. They rise on the third rising edge after por_n rises, if the clock has already settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Always-on domain reset, active low (supply start-up) |
| stby_req_n | input | 1 | Hardware standby request pin, active low, asynchronous |
| por_n | input | 1 | Power-on reset pin, active low, asynchronous |
| strap_sck | input | 1 | Serial-clock strap pin, asynchronous |
| sw_standby | input | 1 | Clock generator is in software standby with its clock stopped |
| wdt_exit_active | input | 1 | Watchdog is timing an interrupt-triggered standby exit |
| cpu_restart_done | input | 1 | CPU reports it has restarted (used in the wake phase) |
| status_hiz_sel | input | 1 | Control bit: 1 puts the status pin high-Z in hardware standby |
| irq_req | input | 1 | Interrupt request toward the CPU |
| mrst_req | input | 1 | Manual reset request toward the CPU |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| rtc_en | output | 1 | Real-time clock enable |
| osc_en | output | 1 | Oscillator enable |
| pad_oe | output | 1 | Global output enable for ordinary pads |
| pad_pu | output | 1 | Global pull-up enable for pads |
| status_oe | output | 1 | Output enable for the status pin |
| irq_out | output | 1 | Gated interrupt request |
| mrst_out | output | 1 | Gated manual reset request |
| clk_stable | output | 1 | Oscillator settling period has elapsed |
| proto_err | output | 1 | Sticky flag: exit attempted out of order |

## Verification
The assertions assume that sw_standby, wdt_exit_active, cpu_restart_done and the request inputs are synchronous to the always-on clock. They also assume that por_n and strap_sck are steady for at least two clock cycles before the request pin rises, so the synchronized values seen at the edge are the intended ones. The bench drives every input on the falling clock edge. It changes the pins only after holding the previous levels for three or more cycles. It sweeps all eight combinations of sw_standby, wdt_exit_active and status_hiz_sel for entry, and all four combinations of por_n and strap_sck for exit.

// File: rtl/hw_sby_pkg.sv
package hw_sby_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_RUN   = 2'd1,
    ST_WAKE  = 2'd2,
    ST_HWSBY = 2'd3
  } sby_state_e;
endpackage

// File: rtl/hw_sby_sync.sv
module hw_sby_sync #(
  parameter int           W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hw_sby_settle_timer.sv
module hw_sby_settle_timer #(
  parameter int CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic stable
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clear)                cnt <= '0;
    else if (run && cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign stable = (cnt == LIMIT);
endmodule

// File: rtl/hw_sby_outmap.sv
module hw_sby_outmap
  import hw_sby_pkg::*;
(
  input  sby_state_e state,
  input  logic       sw_standby,
  input  logic       wdt_exit_active,
  input  logic       status_hiz_sel,
  input  logic       irq_req,
  input  logic       mrst_req,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       pad_oe,
  output logic       pad_pu,
  output logic       status_oe,
  output logic       irq_out,
  output logic       mrst_out
);
  logic in_sby;
  assign in_sby = (state == ST_HWSBY);

  always_comb begin
    cpu_clk_en = 1'b0;
    osc_en     = 1'b0;
    unique case (state)
      ST_START: osc_en = 1'b1;
      ST_RUN: begin
        cpu_clk_en = ~sw_standby;
        osc_en     = ~sw_standby | wdt_exit_active;
      end
      ST_WAKE: begin
        cpu_clk_en = 1'b1;
        osc_en     = 1'b1;
      end
      ST_HWSBY: ;
      default: ;
    endcase
  end

  assign per_clk_en = cpu_clk_en;
  assign pad_oe     = ~in_sby;
  assign pad_pu     = ~in_sby;
  assign status_oe  = ~in_sby | ~status_hiz_sel;
  assign irq_out    = irq_req & ~in_sby;
  assign mrst_out   = mrst_req & ~in_sby;
endmodule

// File: rtl/hw_standby_ctrl.sv
module hw_standby_ctrl
  import hw_sby_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_req_n,
  input  logic por_n,
  input  logic strap_sck,
  input  logic sw_standby,
  input  logic wdt_exit_active,
  input  logic cpu_restart_done,
  input  logic status_hiz_sel,
  input  logic irq_req,
  input  logic mrst_req,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic rtc_en,
  output logic osc_en,
  output logic pad_oe,
  output logic pad_pu,
  output logic status_oe,
  output logic irq_out,
  output logic mrst_out,
  output logic clk_stable,
  output logic proto_err
);
  localparam int          NSYNC     = 3;
  localparam logic [NSYNC-1:0] SYNC_INIT = 3'b001; // request idles high

  logic [NSYNC-1:0] sync_q;
  logic req_s, por_s, strap_s, req_q, req_rise, err_set;
  sby_state_e state, state_nx;

  hw_sby_sync #(.W(NSYNC), .INIT(SYNC_INIT)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({strap_sck, por_n, stby_req_n}),
    .q(sync_q)
  );
  assign req_s   = sync_q[0];
  assign por_s   = sync_q[1];
  assign strap_s = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b1;
    else        req_q <= req_s;
  end
  assign req_rise = req_s & ~req_q;

  hw_sby_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run(state == ST_START),
    .clear(state == ST_HWSBY),
    .stable(clk_stable)
  );

  always_comb begin
    state_nx = state;
    err_set  = 1'b0;
    unique case (state)
      ST_START: if (clk_stable && por_s) state_nx = ST_RUN;
      ST_RUN:   if (!req_s) state_nx = wdt_exit_active ? ST_WAKE : ST_HWSBY;
      ST_WAKE:  if (cpu_restart_done) state_nx = ST_HWSBY;
      ST_HWSBY: if (req_rise) begin
        if (!por_s && strap_s) state_nx = ST_START;
        else                   err_set  = 1'b1;
      end
      default:  state_nx = ST_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_START;
      proto_err <= 1'b0;
      rtc_en    <= 1'b0;
    end else begin
      state     <= state_nx;
      rtc_en    <= 1'b1;
      if (err_set) proto_err <= 1'b1;
    end
  end

  hw_sby_outmap u_out (
    .state(state), .sw_standby(sw_standby), .wdt_exit_active(wdt_exit_active),
    .status_hiz_sel(status_hiz_sel), .irq_req(irq_req), .mrst_req(mrst_req),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .status_oe(status_oe),
    .irq_out(irq_out), .mrst_out(mrst_out)
  );
endmodule

// File: rtl/hw_sby_chk.sv
module hw_sby_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state,
  input logic       por_s,
  input logic       strap_s,
  input logic       clk_stable,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       osc_en,
  input logic       rtc_en,
  input logic       pad_oe,
  input logic       pad_pu,
  input logic       irq_out,
  input logic       mrst_out,
  input logic       proto_err
);
  localparam logic [1:0] S_START = 2'd0;
  localparam logic [1:0] S_RUN   = 2'd1;
  localparam logic [1:0] S_HWSBY = 2'd3;

  assert_sby_clocks_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HWSBY) |-> (!cpu_clk_en && !per_clk_en && !osc_en && rtc_en));

  assert_sby_pads_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HWSBY) |-> (!pad_oe && !pad_pu));

  assert_sby_req_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HWSBY) |-> (!irq_out && !mrst_out));

  assert_start_no_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_START) |-> (state != S_HWSBY));

  assert_exit_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_HWSBY && state != S_HWSBY) |->
      (state == S_START && !$past(por_s) && $past(strap_s)));

  assert_clk_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_START && state == S_RUN) |-> ($past(clk_stable) && $past(por_s)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(proto_err) |-> proto_err);
endmodule

bind hw_standby_ctrl hw_sby_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .por_s(por_s), .strap_s(strap_s),
  .clk_stable(clk_stable), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .osc_en(osc_en), .rtc_en(rtc_en), .pad_oe(pad_oe), .pad_pu(pad_pu),
  .irq_out(irq_out), .mrst_out(mrst_out), .proto_err(proto_err)
);

// File: tb/hw_standby_ctrl_test.sv
module hw_standby_ctrl_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n, stby_req_n, por_n, strap_sck, sw_standby, wdt_exit_active;
  logic cpu_restart_done, status_hiz_sel, irq_req, mrst_req;
  logic cpu_clk_en, per_clk_en, rtc_en, osc_en, pad_oe, pad_pu, status_oe;
  logic irq_out, mrst_out, clk_stable, proto_err;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  hw_standby_ctrl #(.SETTLE_CYCLES(N)) uut (
    .clk(clk), .rst_n(rst_n), .stby_req_n(stby_req_n), .por_n(por_n),
    .strap_sck(strap_sck), .sw_standby(sw_standby), .wdt_exit_active(wdt_exit_active),
    .cpu_restart_done(cpu_restart_done), .status_hiz_sel(status_hiz_sel),
    .irq_req(irq_req), .mrst_req(mrst_req), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .rtc_en(rtc_en), .osc_en(osc_en), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .status_oe(status_oe), .irq_out(irq_out), .mrst_out(mrst_out),
    .clk_stable(clk_stable), .proto_err(proto_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_sby(input logic hiz);
    chk("R4 cpu_clk_en in standby", cpu_clk_en, 0);
    chk("R4 per_clk_en in standby", per_clk_en, 0);
    chk("R4 osc_en in standby", osc_en, 0);
    chk("R4 rtc_en in standby", rtc_en, 1);
    chk("R7 pad_oe in standby", pad_oe, 0);
    chk("R7 pad_pu in standby", pad_pu, 0);
    chk("R7 status_oe in standby", status_oe, int'(!hiz));
    chk("R8 irq_out in standby", irq_out, 0);
    chk("R8 mrst_out in standby", mrst_out, 0);
  endtask

  // from standby with correct pin order back to normal operation
  task automatic do_exit();
    por_n = 1'b0; strap_sck = 1'b1;
    tick(3);
    stby_req_n = 1'b1;
    tick(2);
    chk("R9 still standby before sync", pad_oe, 0);
    tick(1);
    chk("R9 osc_en after exit", osc_en, 1);
    chk("R9 pad_oe after exit", pad_oe, 1);
    chk("R11 cpu_clk_en while unsettled", cpu_clk_en, 0);
    stby_req_n = 1'b0;
    tick(5);
    chk("R3 request ignored in start-up", pad_oe, 1);
    stby_req_n = 1'b1;
    tick(N - 6);
    chk("R2 clk_stable one cycle early", clk_stable, 0);
    tick(1);
    chk("R2 clk_stable on time", clk_stable, 1);
    tick(4);
    chk("R11 cpu_clk_en with por low", cpu_clk_en, 0);
    por_n = 1'b1;
    tick(2);
    chk("R11 cpu_clk_en before por sync", cpu_clk_en, 0);
    tick(1);
    chk("R11 cpu_clk_en after por", cpu_clk_en, 1);
    chk("R11 per_clk_en after por", per_clk_en, 1);
    strap_sck = 1'b0;
    tick(2);
  endtask

  task automatic do_entry(input logic sw, input logic wdt, input logic hiz);
    sw_standby = sw; wdt_exit_active = wdt; status_hiz_sel = hiz;
    irq_req = 1'b1; mrst_req = 1'b1;
    tick(2);
    chk("R5 cpu_clk_en in run", cpu_clk_en, int'(!sw));
    chk("R5 osc_en in run", osc_en, int'(!sw || wdt));
    chk("R7 status_oe in run", status_oe, 1);
    chk("R8 irq_out passes in run", irq_out, 1);
    chk("R8 mrst_out passes in run", mrst_out, 1);
    stby_req_n = 1'b0;
    for (int c = 0; c < 2; c++) begin
      tick(1);
      chk("R4 not yet in standby", pad_oe, 1);
      if (sw && !wdt) chk("R5 cpu clock held off", cpu_clk_en, 0);
    end
    tick(1);
    if (wdt) begin
      for (int c = 0; c < 4; c++) begin
        chk("R6 wake cpu_clk_en", cpu_clk_en, 1);
        chk("R6 wake per_clk_en", per_clk_en, 1);
        chk("R6 wake pads on", pad_oe, 1);
        tick(1);
      end
      cpu_restart_done = 1'b1;
      tick(1);
      cpu_restart_done = 1'b0;
      chk("R6 standby after restart", pad_oe, 0);
    end else if (sw) begin
      chk("R5 cpu clock still off", cpu_clk_en, 0);
    end
    sw_standby = 1'b0; wdt_exit_active = 1'b0;
    chk_sby(hiz);
    irq_req = 1'b0; mrst_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stby_req_n = 1'b1; por_n = 1'b1; strap_sck = 1'b0;
    sw_standby = 1'b0; wdt_exit_active = 1'b0; cpu_restart_done = 1'b0;
    status_hiz_sel = 1'b0; irq_req = 1'b0; mrst_req = 1'b0;
    tick(3);
    chk("R1 osc_en in reset", osc_en, 1);
    chk("R1 rtc_en in reset", rtc_en, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 rtc_en after reset", rtc_en, 1);
    chk("R1 cpu_clk_en", cpu_clk_en, 0);
    chk("R1 clk_stable", clk_stable, 0);
    chk("R1 pad_oe", pad_oe, 1);
    chk("R1 pad_pu", pad_pu, 1);
    chk("R1 proto_err", proto_err, 0);
    tick(N - 1);
    chk("R2 clk_stable at start-up", clk_stable, 1);
    chk("R11 cpu_clk_en not yet", cpu_clk_en, 0);
    tick(1);
    chk("R11 cpu_clk_en after settle", cpu_clk_en, 1);

    for (int k = 0; k < 8; k++) begin
      do_entry(k[0], k[1], k[2]);
      do_exit();
    end

    // exit attempts with wrong pin order
    do_entry(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      por_n = (k != 1); strap_sck = (k == 0);
      tick(3);
      stby_req_n = 1'b1;
      tick(4);
      chk("R10 stays in standby", pad_oe, 0);
      chk("R10 osc stays off", osc_en, 0);
      chk("R10 proto_err set", proto_err, 1);
      stby_req_n = 1'b0;
      tick(3);
    end
    do_exit();
    chk("R10 proto_err sticky after exit", proto_err, 1);
    rst_n = 1'b0;
    tick(2);
    chk("R10 proto_err cleared by reset", proto_err, 0);
    chk("R1 clk_stable cleared by reset", clk_stable, 0);
    rst_n = 1'b1;
    tick(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule